// File: doc/BRIEF.md
# Sixteen-Register Byte ALU with Shared Flag Register

This block holds the sixteen 8-bit general registers of a small byte machine. It also executes that machine's register-to-register arithmetic and logic group. A caller raises a start strobe together with a 4-bit operation code and two register indices, X and Y. On the next clock edge the block writes the result into register X and, for the arithmetic and shift operations, writes a 0/1 flag into the last register, index 15, called VF here. VF is also an ordinary register. When VF is the destination, a fixed per-operation rule decides whether the result or the flag is left in it.

A second command path loads an immediate byte into register X or adds one to it, without touching the flag. Every register is visible at all times on a flattened debug bus, so surrounding logic or a bench can read the full machine state. Operation codes outside the defined set pulse an error output and change nothing.

Top module: `regalu_top`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to 0x00 and drives done and illegal low; register i appears on regs_o bits [8*i+7 : 8*i].
- R2: Opcodes 0x0, 0x1, 0x2 and 0x3 write VY, VX|VY, VX&VY and VX^VY into VX, and leave VF unchanged unless X is 15.
- R3: Opcode 0x4 writes (VX+VY) mod 256 into VX and sets VF to 0x01 when the true sum is above 255, else 0x00.
- R4: Opcode 0x5 writes (VX−VY) mod 256 into VX and sets VF to 0x01 when VX ≥ VY, else 0x00.
- R5: Opcode 0x7 writes (VY−VX) mod 256 into VX and sets VF to 0x01 when VY ≥ VX, else 0x00.
- R6: Opcode 0x6 shifts VX right by one and opcode 0xE shifts it left by one, filling with zero. VF receives the bit shifted out (old bit 0 or old bit 7), and VY has no effect.
- R7: For opcodes 0x4, 0x5 and 0x7 with X = 15, VF ends holding the 8-bit result, not the flag.
- R8: For opcodes 0x6 and 0xE with X = 15, VF ends holding the shifted-out bit, not the shifted value.
- R9: With imm_en high and imm_add low, imm_val is written into VX. With imm_add high, (VX+imm_val) mod 256 is written into VX. In neither case does VF change, unless X is 15.
- R10: A legal operation takes effect at the first clock edge after start is sampled. done is high for exactly that one following cycle, and the register update is visible in the same cycle.
- R11: Opcodes 0x8–0xD and 0xF pulse illegal for one cycle, leave done low and change no register.
- R12: If start and imm_en are both high in one cycle, the ALU operation is executed and the immediate command is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Execute the ALU operation given by op_i, x_i and y_i |
| op_i | input | 4 | ALU operation code |
| x_i | input | 4 | Destination and first source register index |
| y_i | input | 4 | Second source register index |
| imm_en_i | input | 1 | Execute an immediate command on register x_i |
| imm_add_i | input | 1 | Immediate mode: 0 loads, 1 adds |
| imm_val_i | input | 8 | Immediate byte |
| done_o | output | 1 | One-cycle pulse when a legal operation has completed |
| illegal_o | output | 1 | One-cycle pulse when an undefined opcode was started |
| regs_o | output | 128 | All registers, register i at bits [8*i+7:8*i] |

## Verification
Within one operation, the result write and the flag write both land in one cycle. When X is 15, both target VF, and the bench uses add, subtract, reverse subtract and both shifts with X = 15. For each case it picks operands whose result and flag differ, so the value left in VF shows which write won. The second collision is between the start strobe and the immediate command. The bench raises both in one cycle with an immediate value that differs from the arithmetic result, then checks that VX holds the sum and done pulses.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

  localparam logic [3:0] OP_MOV  = 4'h0;
  localparam logic [3:0] OP_OR   = 4'h1;
  localparam logic [3:0] OP_AND  = 4'h2;
  localparam logic [3:0] OP_XOR  = 4'h3;
  localparam logic [3:0] OP_ADD  = 4'h4;
  localparam logic [3:0] OP_SUB  = 4'h5;
  localparam logic [3:0] OP_SHR  = 4'h6;
  localparam logic [3:0] OP_RSUB = 4'h7;
  localparam logic [3:0] OP_SHL  = 4'hE;

  // Which write wins when the destination is also the flag register
  typedef enum logic {
    WIN_RESULT = 1'b0,
    WIN_FLAG   = 1'b1
  } flag_order_e;

endpackage

// File: rtl/regalu_exec.sv
module regalu_exec
  import regalu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] vx_i,
  input  logic [DW-1:0] vy_i,
  output logic [DW-1:0] res_o,
  output logic          flag_o,
  output logic          flag_we_o,
  output flag_order_e   order_o,
  output logic          legal_o
);

  logic [DW:0] sum_w;
  logic [DW:0] dxy_w;
  logic [DW:0] dyx_w;

  always_comb begin
    sum_w = {1'b0, vx_i} + {1'b0, vy_i};
    dxy_w = {1'b0, vx_i} - {1'b0, vy_i};
    dyx_w = {1'b0, vy_i} - {1'b0, vx_i};
  end

  always_comb begin
    res_o     = vx_i;
    flag_o    = 1'b0;
    flag_we_o = 1'b0;
    order_o   = WIN_RESULT;
    legal_o   = 1'b1;
    case (op_i)
      OP_MOV: res_o = vy_i;
      OP_OR:  res_o = vx_i | vy_i;
      OP_AND: res_o = vx_i & vy_i;
      OP_XOR: res_o = vx_i ^ vy_i;
      OP_ADD: begin
        res_o     = sum_w[DW-1:0];
        flag_o    = sum_w[DW];
        flag_we_o = 1'b1;
      end
      OP_SUB: begin
        res_o     = dxy_w[DW-1:0];
        flag_o    = ~dxy_w[DW];
        flag_we_o = 1'b1;
      end
      OP_RSUB: begin
        res_o     = dyx_w[DW-1:0];
        flag_o    = ~dyx_w[DW];
        flag_we_o = 1'b1;
      end
      OP_SHR: begin
        res_o     = {1'b0, vx_i[DW-1:1]};
        flag_o    = vx_i[0];
        flag_we_o = 1'b1;
        order_o   = WIN_FLAG;
      end
      OP_SHL: begin
        res_o     = {vx_i[DW-2:0], 1'b0};
        flag_o    = vx_i[DW-1];
        flag_we_o = 1'b1;
        order_o   = WIN_FLAG;
      end
      default: legal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/regalu_regfile.sv
module regalu_regfile
  import regalu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wa_we_i,
  input  logic [$clog2(NREG)-1:0] wa_idx_i,
  input  logic [DW-1:0]      wa_data_i,
  input  logic               wf_we_i,
  input  logic [DW-1:0]      wf_data_i,
  input  flag_order_e        wf_order_i,
  output logic [NREG*DW-1:0] regs_o
);

  localparam int IW       = $clog2(NREG);
  localparam int FLAG_IDX = NREG - 1;

  logic [DW-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit IS_FLAG = (i == FLAG_IDX);
    logic a_hit;
    logic f_take;
    assign a_hit  = wa_we_i && (wa_idx_i == IW'(i));
    assign f_take = IS_FLAG && wf_we_i && ((wf_order_i == WIN_FLAG) || !a_hit);

    always_ff @(posedge clk) begin
      if (rst)         q[i] <= '0;
      else if (f_take) q[i] <= wf_data_i;
      else if (a_hit)  q[i] <= wa_data_i;
    end

    assign regs_o[i*DW +: DW] = q[i];
  end

  logic [DW-1:0] vf_w;
  assign vf_w = regs_o[FLAG_IDX*DW +: DW];

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wa_we_i && !wf_we_i) |=> $stable(regs_o));

  // R8
  flag_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wf_we_i && wa_we_i && wa_idx_i == IW'(FLAG_IDX) && wf_order_i == WIN_FLAG)
      |=> vf_w == $past(wf_data_i));

  // R7
  result_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wf_we_i && wa_we_i && wa_idx_i == IW'(FLAG_IDX) && wf_order_i == WIN_RESULT)
      |=> vf_w == $past(wa_data_i));

endmodule

// File: rtl/regalu_top.sv
module regalu_top
  import regalu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [3:0]              op_i,
  input  logic [$clog2(NREG)-1:0] x_i,
  input  logic [$clog2(NREG)-1:0] y_i,
  input  logic                    imm_en_i,
  input  logic                    imm_add_i,
  input  logic [DW-1:0]           imm_val_i,
  output logic                    done_o,
  output logic                    illegal_o,
  output logic [NREG*DW-1:0]      regs_o
);

  localparam int IW       = $clog2(NREG);
  localparam int FLAG_IDX = NREG - 1;

  logic [DW-1:0] vx_w, vy_w, vf_w;
  logic [DW-1:0] res_w;
  logic          flag_w, flag_we_w, legal_w;
  flag_order_e   order_w;

  assign vx_w = regs_o[x_i*DW +: DW];
  assign vy_w = regs_o[y_i*DW +: DW];
  assign vf_w = regs_o[FLAG_IDX*DW +: DW];

  regalu_exec #(.DW(DW)) u_exec (
    .op_i      (op_i),
    .vx_i      (vx_w),
    .vy_i      (vy_w),
    .res_o     (res_w),
    .flag_o    (flag_w),
    .flag_we_o (flag_we_w),
    .order_o   (order_w),
    .legal_o   (legal_w)
  );

  logic          alu_go, imm_go;
  logic          wa_we, wf_we;
  logic [DW-1:0] wa_data, wf_data;

  always_comb begin
    alu_go  = start_i && legal_w;
    imm_go  = imm_en_i && !start_i;
    wa_we   = alu_go || imm_go;
    if (alu_go)         wa_data = res_w;
    else if (imm_add_i) wa_data = vx_w + imm_val_i;
    else                wa_data = imm_val_i;
    wf_we   = alu_go && flag_we_w;
    wf_data = {{(DW-1){1'b0}}, flag_w};
  end

  regalu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk        (clk),
    .rst        (rst),
    .wa_we_i    (wa_we),
    .wa_idx_i   (x_i),
    .wa_data_i  (wa_data),
    .wf_we_i    (wf_we),
    .wf_data_i  (wf_data),
    .wf_order_i (order_w),
    .regs_o     (regs_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= alu_go;
      illegal_o <= start_i && !legal_w;
    end
  end

  // R10
  done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && legal_w) |=> done_o);

  // R11
  illegal_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !legal_w) |=> (illegal_o && !done_o && $stable(regs_o)));

  // R11
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && illegal_o));

  // R2
  logic_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && op_i <= OP_XOR && x_i != IW'(FLAG_IDX)) |=> $stable(vf_w));

  // R9
  imm_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (imm_en_i && !start_i && x_i != IW'(FLAG_IDX)) |=> $stable(vf_w));

  // R6
  shr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && op_i == OP_SHR && x_i != IW'(FLAG_IDX))
      |=> vf_w == {{(DW-1){1'b0}}, $past(vx_w[0])});

endmodule

// File: tb/regalu_top_tb.sv
module regalu_top_tb;

  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [3:0]   op_i, x_i, y_i;
  logic         imm_en_i, imm_add_i;
  logic [7:0]   imm_val_i;
  logic         done_o, illegal_o;
  logic [127:0] regs_o;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  regalu_top u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .x_i(x_i), .y_i(y_i),
    .imm_en_i(imm_en_i), .imm_add_i(imm_add_i), .imm_val_i(imm_val_i),
    .done_o(done_o), .illegal_o(illegal_o), .regs_o(regs_o)
  );

  typedef struct packed {
    logic [3:0] op, x, y;
    logic [7:0] a, b, ev, ef;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 4'h1, 4'h2, 8'h12, 8'h34, 8'h34, 8'h55}, // R2 copy
    '{4'h1, 4'h3, 4'h4, 8'hF0, 8'h0F, 8'hFF, 8'h55}, // R2 or
    '{4'h2, 4'h3, 4'h4, 8'h3C, 8'h0F, 8'h0C, 8'h55}, // R2 and
    '{4'h3, 4'h5, 4'h6, 8'hFF, 8'h0F, 8'hF0, 8'h55}, // R2 xor
    '{4'h4, 4'h1, 4'h2, 8'h80, 8'h80, 8'h00, 8'h01}, // R3 carry
    '{4'h4, 4'h1, 4'h2, 8'h10, 8'h20, 8'h30, 8'h00}, // R3 no carry
    '{4'h4, 4'h1, 4'h2, 8'hFF, 8'h01, 8'h00, 8'h01}, // R3 wrap
    '{4'h5, 4'h1, 4'h2, 8'h20, 8'h10, 8'h10, 8'h01}, // R4 no borrow
    '{4'h5, 4'h1, 4'h2, 8'h10, 8'h20, 8'hF0, 8'h00}, // R4 borrow
    '{4'h5, 4'h1, 4'h2, 8'h42, 8'h42, 8'h00, 8'h01}, // R4 equal
    '{4'h7, 4'h1, 4'h2, 8'h10, 8'h20, 8'h10, 8'h01}, // R5 no borrow
    '{4'h7, 4'h1, 4'h2, 8'h20, 8'h10, 8'hF0, 8'h00}, // R5 borrow
    '{4'h6, 4'h1, 4'h2, 8'h81, 8'hFF, 8'h40, 8'h01}, // R6 right
    '{4'hE, 4'h1, 4'h2, 8'h81, 8'h00, 8'h02, 8'h01}, // R6 left out 1
    '{4'hE, 4'h1, 4'h2, 8'h40, 8'hFF, 8'h80, 8'h00}, // R6 left out 0
    '{4'h4, 4'hF, 4'h2, 8'hF0, 8'h20, 8'h10, 8'h10}, // R7 add into VF
    '{4'h5, 4'hF, 4'h2, 8'h05, 8'h10, 8'hF5, 8'hF5}, // R7 sub into VF
    '{4'h7, 4'hF, 4'h2, 8'h30, 8'h10, 8'hE0, 8'hE0}, // R7 rsub into VF
    '{4'h6, 4'hF, 4'h2, 8'h02, 8'h00, 8'h00, 8'h00}, // R8 shr into VF
    '{4'hE, 4'hF, 4'h2, 8'h80, 8'h00, 8'h01, 8'h01}, // R8 shl into VF
    '{4'h0, 4'hF, 4'h2, 8'h11, 8'h22, 8'h22, 8'h22}  // R2 copy into VF
  };

  function automatic logic [7:0] rd(input int idx);
    return regs_o[idx*8 +: 8];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic imm(input logic [3:0] x, input logic [7:0] v, input logic add);
    @(negedge clk);
    imm_en_i = 1'b1; imm_add_i = add; x_i = x; imm_val_i = v;
    @(negedge clk);
    imm_en_i = 1'b0; imm_add_i = 1'b0;
  endtask

  task automatic alu(input logic [3:0] op, input logic [3:0] x, input logic [3:0] y);
    @(negedge clk);
    start_i = 1'b1; op_i = op; x_i = x; y_i = y;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; op_i = '0; x_i = '0; y_i = '0;
    imm_en_i = 1'b0; imm_add_i = 1'b0; imm_val_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 regs", {7'b0, regs_o == '0}, 8'h01);
    chk("R1 done", {7'b0, done_o}, 8'h00);
    chk("R1 illegal", {7'b0, illegal_o}, 8'h00);

    // Vector table walk
    for (int k = 0; k < NV; k++) begin
      imm(4'hF, 8'h55, 1'b0);
      imm(VECS[k].x, VECS[k].a, 1'b0);
      imm(VECS[k].y, VECS[k].b, 1'b0);
      alu(VECS[k].op, VECS[k].x, VECS[k].y);
      chk($sformatf("vec%0d VX", k), rd(int'(VECS[k].x)), VECS[k].ev);
      chk($sformatf("vec%0d VF", k), rd(15), VECS[k].ef);
      chk($sformatf("vec%0d R10 done", k), {7'b0, done_o}, 8'h01);
    end

    // R10 done lasts one cycle
    @(negedge clk);
    chk("R10 done drop", {7'b0, done_o}, 8'h00);

    // R9 immediate load and add leave VF alone
    imm(4'hF, 8'h77, 1'b0);
    imm(4'h3, 8'hF0, 1'b0);
    chk("R9 load", rd(3), 8'hF0);
    imm(4'h3, 8'h20, 1'b1);
    chk("R9 add wrap", rd(3), 8'h10);
    chk("R9 VF kept", rd(15), 8'h77);
    chk("R9 no done", {7'b0, done_o}, 8'h00);

    // R11 undefined opcodes
    foreach (VECS[0].op[b]) begin end
    for (int op = 8; op < 16; op++) begin
      logic [127:0] snap;
      if (op == 14) continue;
      imm(4'h1, 8'h81, 1'b0);
      imm(4'h2, 8'h7F, 1'b0);
      snap = regs_o;
      alu(op[3:0], 4'h1, 4'h2);
      chk($sformatf("R11 illegal op %h", op), {7'b0, illegal_o}, 8'h01);
      chk($sformatf("R11 no done op %h", op), {7'b0, done_o}, 8'h00);
      chk($sformatf("R11 regs kept op %h", op), {7'b0, regs_o == snap}, 8'h01);
      @(negedge clk);
      chk($sformatf("R11 pulse end op %h", op), {7'b0, illegal_o}, 8'h00);
    end

    // R12 start and immediate together: ALU wins
    imm(4'h1, 8'h10, 1'b0);
    imm(4'h2, 8'h20, 1'b0);
    @(negedge clk);
    start_i = 1'b1; op_i = 4'h4; x_i = 4'h1; y_i = 4'h2;
    imm_en_i = 1'b1; imm_add_i = 1'b0; imm_val_i = 8'h99;
    @(negedge clk);
    start_i = 1'b0; imm_en_i = 1'b0;
    chk("R12 VX sum", rd(1), 8'h30);
    chk("R12 done", {7'b0, done_o}, 8'h01);

    // R1 reset mid-run
    imm(4'h5, 8'hAB, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 cleared", {7'b0, regs_o == '0}, 8'h01);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule